// File: doc/BRIEF.md
# SDRAM Command Bus Monitor

This block watches the command pins of a synchronous DRAM interface. On every rising clock edge it turns chip select, row strobe, column strobe and write enable into one command code. It keeps a record of which banks hold an open row. It also remembers whether the mode register has been loaded since reset. When a command breaks a sequencing rule, it raises one error strobe per rule.

The block is a passive observer. It drives nothing back onto the bus, and it decodes every command even when that command is illegal. An activate issued before the mode register is loaded still opens its bank, and a mode load that is flagged still counts as done. The block does not check data or electrical timing. It does check the activate-to-column spacing, counted in whole clock cycles against the parameter `TRCD`.

All outputs are registered. In the cycle after an edge, `cmd_code` and the error strobes describe the command sampled at that edge, and `bank_open` shows the bank state after that command.

Top module: `sdr_cmd_monitor`

## Requirements
- R1: With chip select low, the pin triple (row, column, write strobe; 0 = asserted low) decodes to `cmd_code` as follows: 011 gives ACT=1, 101 gives READ=2, 100 gives WRITE=3, 010 gives PRECHARGE=4, 000 gives MODE_LOAD=5, 111 gives NOP=0, and any other triple gives OTHER=6. The code appears in the cycle after the edge.
- R2: While `cs_n` is high, the command is treated as a deselect. `cmd_code` shows 0, no bank changes state, and no error strobe rises, whatever the other pins carry.
- R3: An ACT opens the bank selected by `ba`, so its bit in `bank_open` reads 1 from the next cycle.
- R4: A PRECHARGE with `a10` high closes every bank. With `a10` low it closes only the bank selected by `ba`.
- R5: A MODE_LOAD while any bank is open pulses `err_mrs_busy`.
- R6: A MODE_LOAD whose preceding clock edge sampled `cke` low pulses `err_mrs_cke`. The sample taken before reset release counts as low.
- R7: An ACT seen before any MODE_LOAD since reset pulses `err_act_nomode`.
- R8: A READ or WRITE to an open bank fewer than `TRCD` edges after that bank's ACT pulses `err_trcd`. At exactly `TRCD` edges or more, no error is raised.
- R9: A READ or WRITE to a bank that is not open pulses `err_col_closed` and does not also raise `err_trcd`.
- R10: During and right after reset, `cmd_code` is 0, `bank_open` is all zero and every error strobe is low.
- R11: Each error strobe is high for exactly the one cycle that follows the offending command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| cke | input | 1 | Clock enable |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Address bit selecting all banks on precharge |
| cmd_code | output | 3 | Decoded command code |
| bank_open | output | 2**BA_W | One bit per bank, 1 when a row is open |
| err_mrs_busy | output | 1 | Mode load while a bank is open |
| err_mrs_cke | output | 1 | Mode load without clock enable on the prior edge |
| err_act_nomode | output | 1 | Activate before any mode load |
| err_trcd | output | 1 | Column command too soon after activate |
| err_col_closed | output | 1 | Column command to a closed bank |

## Verification
The decoder is driven with every pin triple, including refresh and burst-stop patterns, which must land on OTHER and not on a real command. It is also driven with deselect cycles that carry the precharge-all and mode-load patterns. Those cycles show whether chip select really masks the command, because acting on them would close a bank or flag an error. Column commands are placed one edge and exactly `TRCD` edges after an activate, which separates a strict bound from an inclusive one. Column commands are also sent to closed banks, to show that the two column errors never fire together. A low `cke` cycle comes right before a mode load, so the bench can tell the prior-edge rule apart from a check of `cke` in the current cycle.

// File: rtl/sdr_mon_pkg.sv
package sdr_mon_pkg;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_ACT   = 3'd1,
        CMD_RD    = 3'd2,
        CMD_WR    = 3'd3,
        CMD_PRE   = 3'd4,
        CMD_MRS   = 3'd5,
        CMD_OTHER = 3'd6
    } cmd_e;

    typedef struct packed {
        logic mrs_busy;
        logic mrs_cke;
        logic act_nomode;
        logic trcd;
        logic col_closed;
    } err_t;

    // Pin triple order is {ras_n, cas_n, we_n}; chip select high masks all.
    function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                        input logic cas_n, input logic we_n);
        if (cs_n) return CMD_NOP;
        case ({ras_n, cas_n, we_n})
            3'b011:  return CMD_ACT;
            3'b101:  return CMD_RD;
            3'b100:  return CMD_WR;
            3'b010:  return CMD_PRE;
            3'b000:  return CMD_MRS;
            3'b111:  return CMD_NOP;
            default: return CMD_OTHER;
        endcase
    endfunction

endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
    import sdr_mon_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    always_comb begin
        cmd = decode_cmd(cs_n, ras_n, cas_n, we_n);
    end

endmodule

// File: rtl/sdr_bank_track.sv
module sdr_bank_track
    import sdr_mon_pkg::*;
#(
    parameter int BA_W = 2,
    parameter int TRCD = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  cmd_e                  cmd,
    input  logic [BA_W-1:0]       ba,
    input  logic                  a10,
    output logic [(1<<BA_W)-1:0]  bank_open,
    output logic [(1<<BA_W)-1:0]  trcd_met
);

    localparam int NUM_BANKS = 1 << BA_W;
    localparam int CNT_W     = (TRCD < 2) ? 1 : $clog2(TRCD + 1);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(TRCD);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic             hit;
        logic             open_q;
        logic [CNT_W-1:0] since_act;

        assign hit = (ba == BA_W'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                open_q    <= 1'b0;
                since_act <= CNT_SAT;
            end else if (cmd == CMD_ACT && hit) begin
                open_q    <= 1'b1;
                since_act <= CNT_W'(1);
            end else begin
                if (cmd == CMD_PRE && (a10 || hit)) open_q <= 1'b0;
                if (since_act < CNT_SAT) since_act <= since_act + 1'b1;
            end
        end

        assign bank_open[b] = open_q;
        assign trcd_met[b]  = (since_act >= CNT_SAT);
    end

endmodule

// File: rtl/sdr_rule_check.sv
module sdr_rule_check
    import sdr_mon_pkg::*;
#(
    parameter int BA_W = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  cmd_e                  cmd,
    input  logic                  cke,
    input  logic [BA_W-1:0]       ba,
    input  logic [(1<<BA_W)-1:0]  bank_open,
    input  logic [(1<<BA_W)-1:0]  trcd_met,
    output cmd_e                  cmd_q,
    output err_t                  err_q
);

    logic mode_done;
    logic cke_prev;
    logic is_col;
    logic sel_open;
    err_t err_d;

    always_comb begin
        is_col            = (cmd == CMD_RD) || (cmd == CMD_WR);
        sel_open          = bank_open[ba];
        err_d             = '0;
        err_d.mrs_busy    = (cmd == CMD_MRS) && (|bank_open);
        err_d.mrs_cke     = (cmd == CMD_MRS) && !cke_prev;
        err_d.act_nomode  = (cmd == CMD_ACT) && !mode_done;
        err_d.col_closed  = is_col && !sel_open;
        err_d.trcd        = is_col && sel_open && !trcd_met[ba];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q     <= CMD_NOP;
            err_q     <= '0;
            mode_done <= 1'b0;
            cke_prev  <= 1'b0;
        end else begin
            cmd_q    <= cmd;
            err_q    <= err_d;
            cke_prev <= cke;
            if (cmd == CMD_MRS) mode_done <= 1'b1;
        end
    end

endmodule

// File: rtl/sdr_cmd_monitor.sv
module sdr_cmd_monitor
    import sdr_mon_pkg::*;
#(
    parameter int BA_W = 2,
    parameter int TRCD = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cs_n,
    input  logic                  ras_n,
    input  logic                  cas_n,
    input  logic                  we_n,
    input  logic                  cke,
    input  logic [BA_W-1:0]       ba,
    input  logic                  a10,
    output logic [2:0]            cmd_code,
    output logic [(1<<BA_W)-1:0]  bank_open,
    output logic                  err_mrs_busy,
    output logic                  err_mrs_cke,
    output logic                  err_act_nomode,
    output logic                  err_trcd,
    output logic                  err_col_closed
);

    localparam int NUM_BANKS = 1 << BA_W;

    cmd_e                 cur_cmd;
    cmd_e                 cmd_q;
    err_t                 err_q;
    logic [NUM_BANKS-1:0] open_vec;
    logic [NUM_BANKS-1:0] trcd_met;

    sdr_cmd_decode u_decode (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cur_cmd)
    );

    sdr_bank_track #(.BA_W(BA_W), .TRCD(TRCD)) u_banks (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cur_cmd),
        .ba        (ba),
        .a10       (a10),
        .bank_open (open_vec),
        .trcd_met  (trcd_met)
    );

    sdr_rule_check #(.BA_W(BA_W)) u_rules (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cur_cmd),
        .cke       (cke),
        .ba        (ba),
        .bank_open (open_vec),
        .trcd_met  (trcd_met),
        .cmd_q     (cmd_q),
        .err_q     (err_q)
    );

    assign cmd_code       = cmd_q;
    assign bank_open      = open_vec;
    assign err_mrs_busy   = err_q.mrs_busy;
    assign err_mrs_cke    = err_q.mrs_cke;
    assign err_act_nomode = err_q.act_nomode;
    assign err_trcd       = err_q.trcd;
    assign err_col_closed = err_q.col_closed;

endmodule

// File: rtl/sdr_cmd_monitor_chk.sv
module sdr_cmd_monitor_chk #(
    parameter int BA_W = 2
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  cs_n,
    input logic                  ras_n,
    input logic                  cas_n,
    input logic                  we_n,
    input logic [BA_W-1:0]       ba,
    input logic                  a10,
    input logic [2:0]            cmd_code,
    input logic [(1<<BA_W)-1:0]  bank_open,
    input logic                  err_mrs_busy,
    input logic                  err_mrs_cke,
    input logic                  err_act_nomode,
    input logic                  err_trcd,
    input logic                  err_col_closed
);

    logic pin_act, pin_pre, pin_mrs, pin_col;
    assign pin_act = !cs_n && !ras_n &&  cas_n &&  we_n;
    assign pin_pre = !cs_n && !ras_n &&  cas_n && !we_n;
    assign pin_mrs = !cs_n && !ras_n && !cas_n && !we_n;
    assign pin_col = !cs_n &&  ras_n && !cas_n;

    AST_ACT_OPENS_BANK: assert property (@(posedge clk) disable iff (rst)
        pin_act |=> bank_open[$past(ba)]); // R3

    AST_PRE_ALL_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (pin_pre && a10) |=> (bank_open == '0)); // R4

    AST_DESELECT_INERT: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (cmd_code == 3'd0 && $stable(bank_open) && !err_mrs_busy
                  && !err_mrs_cke && !err_act_nomode && !err_trcd
                  && !err_col_closed)); // R2

    AST_MRS_BUSY_FLAG: assert property (@(posedge clk) disable iff (rst)
        (pin_mrs && |bank_open) |=> err_mrs_busy); // R5

    AST_COL_CLOSED_FLAG: assert property (@(posedge clk) disable iff (rst)
        (pin_col && !bank_open[ba]) |=> (err_col_closed && !err_trcd)); // R9

    AST_COL_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        err_trcd |-> !err_col_closed); // R8

endmodule

bind sdr_cmd_monitor sdr_cmd_monitor_chk #(.BA_W(BA_W)) u_chk (.*);

// File: tb/sdr_cmd_monitor_bench.sv
module sdr_cmd_monitor_bench;

    localparam int BA_W = 2;
    localparam int TRCD = 3;
    localparam int NB   = 1 << BA_W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic          cke = 1'b0;
    logic [BA_W-1:0] ba = '0;
    logic          a10 = 1'b0;
    logic [2:0]    cmd_code;
    logic [NB-1:0] bank_open;
    logic          err_mrs_busy, err_mrs_cke, err_act_nomode, err_trcd, err_col_closed;

    always #5 clk = ~clk;

    sdr_cmd_monitor #(.BA_W(BA_W), .TRCD(TRCD)) u_sdr_cmd_monitor (
        .clk (clk), .rst (rst), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n),
        .we_n (we_n), .cke (cke), .ba (ba), .a10 (a10), .cmd_code (cmd_code),
        .bank_open (bank_open), .err_mrs_busy (err_mrs_busy),
        .err_mrs_cke (err_mrs_cke), .err_act_nomode (err_act_nomode),
        .err_trcd (err_trcd), .err_col_closed (err_col_closed)
    );

    typedef struct {
        logic [2:0]    cmd;
        logic [NB-1:0] open;
        logic [4:0]    err;   // {busy, cke, nomode, trcd, closed}
        string         tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    // Bench model of the requirements
    logic [NB-1:0] m_open = '0;
    bit            m_mode = 0;
    bit            m_cke_prev = 0;
    int            cyc = 0;
    int            act_at[NB];

    function automatic logic [4:0] actual_err();
        return {err_mrs_busy, err_mrs_cke, err_act_nomode, err_trcd, err_col_closed};
    endfunction

    task automatic check(input string tag, input logic [2:0] a_cmd,
                         input logic [NB-1:0] a_open, input logic [4:0] a_err,
                         input exp_t e);
        checks++;
        if (a_cmd !== e.cmd || a_open !== e.open || a_err !== e.err) begin
            errors++;
            $display("FAIL %s: actual cmd=%0d open=%b err=%b, expected cmd=%0d open=%b err=%b",
                     tag, a_cmd, a_open, a_err, e.cmd, e.open, e.err);
        end
    endtask

    task automatic step(input logic c, input logic r, input logic ca, input logic w,
                        input logic k, input int b, input logic a, input string tag);
        exp_t       e;
        logic [2:0] code;
        logic [4:0] er = '0;
        @(negedge clk);
        cs_n = c; ras_n = r; cas_n = ca; we_n = w; cke = k; ba = BA_W'(b); a10 = a;
        cyc++;
        if (c) code = 3'd0;
        else case ({r, ca, w})
            3'b011: code = 3'd1;
            3'b101: code = 3'd2;
            3'b100: code = 3'd3;
            3'b010: code = 3'd4;
            3'b000: code = 3'd5;
            3'b111: code = 3'd0;
            default: code = 3'd6;
        endcase
        case (code)
            3'd5: begin er[4] = |m_open; er[3] = !m_cke_prev; m_mode = 1; end
            3'd1: begin er[2] = !m_mode; m_open[b] = 1'b1; act_at[b] = cyc; end
            3'd2, 3'd3: begin
                if (!m_open[b]) er[0] = 1'b1;
                else if (cyc - act_at[b] < TRCD) er[1] = 1'b1;
            end
            3'd4: if (a) m_open = '0; else m_open[b] = 1'b0;
            default: ;
        endcase
        m_cke_prev = k;
        e.cmd = code; e.open = m_open; e.err = er; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: pops one expected item per edge after the design updates
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, cmd_code, bank_open, actual_err(), e);
            end
        end
    end

    initial begin
        exp_t z;
        foreach (act_at[i]) act_at[i] = -1000;
        z.cmd = 3'd0; z.open = '0; z.err = '0; z.tag = "R10";
        repeat (3) @(negedge clk);
        check("R10 in reset", cmd_code, bank_open, actual_err(), z);
        rst = 1'b0;
        @(negedge clk);
        check("R10 after release", cmd_code, bank_open, actual_err(), z);

        step(0, 1, 1, 1, 1, 0, 0, "R1 nop");
        step(0, 0, 1, 1, 1, 0, 0, "R7 act before mode load");
        step(0, 0, 0, 0, 1, 0, 0, "R5 mode load with bank open");
        step(0, 0, 1, 0, 1, 0, 1, "R4 precharge all");
        step(0, 0, 0, 0, 1, 0, 0, "R1 mode load clean");
        step(0, 1, 1, 1, 0, 0, 0, "R11 nop with cke low");
        step(0, 0, 0, 0, 1, 0, 0, "R6 mode load after cke low");
        step(0, 0, 1, 1, 1, 1, 0, "R3 act bank1");
        step(0, 1, 0, 1, 1, 1, 0, "R8 read one edge after act");
        step(0, 1, 1, 1, 1, 0, 0, "R11 nop");
        step(0, 1, 0, 0, 1, 1, 0, "R8 write at exactly trcd");
        step(0, 1, 0, 1, 1, 2, 0, "R9 read closed bank");
        step(0, 0, 1, 1, 1, 0, 0, "R3 act bank0");
        step(0, 0, 1, 0, 1, 1, 0, "R4 precharge bank1 only");
        step(1, 0, 1, 0, 1, 0, 1, "R2 deselect with precharge-all pins");
        step(1, 0, 0, 0, 1, 0, 0, "R2 deselect with mode load pins");
        step(0, 0, 0, 1, 1, 0, 0, "R1 refresh pattern is other");
        step(0, 1, 1, 0, 1, 0, 0, "R1 burst stop pattern is other");
        step(0, 1, 0, 1, 1, 0, 0, "R1 read open bank late");
        step(0, 1, 0, 0, 1, 1, 0, "R9 write closed bank");
        step(0, 0, 0, 0, 1, 0, 0, "R5 mode load bank0 open");
        step(0, 1, 1, 1, 1, 0, 0, "R11 strobe clears");
        repeat (4) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule